// File: doc/BRIEF.md
# Parallel-ATA bus bring-up sequencer

This block brings a parallel-ATA bus to a known state by driving a simple register-cycle port. It does not time the bus itself. Each register access is handed to a PIO cycle engine as a request. The engine answers with a one-cycle acknowledge and, for reads, the data. On a start command the sequencer first checks whether device 0 exists and, when `slave_ok_i` allows it, whether device 1 exists. It tests each device by writing a fixed alternating pattern into two taskfile registers and reading it back. It then pulses the soft-reset bit of the device-control register and polls status until the devices drop BSY. Device 1 also gets a short signature check. The sequence ends with a fixed series of device-select writes. The result is a two-bit presence mask, a `done` level and an `err` flag.

A second command, drain, empties a device that is stuck with DRQ set. It reads the data register for as long as status shows DRQ, and it stops after a programmable number of bytes. All waits are counts of clock cycles taken from inputs: the two soft-reset gaps, the retry gap and the readiness deadline.

The controlling state machine has these states:

- Idle: `S_IDLE`.
- Probe: `S_PRB_SEL` → `S_PRB_WR` (six writes) → `S_PRB_RD_NS` → `S_PRB_RD_LB`. From `S_PRB_RD_LB` it goes back to `S_PRB_SEL` for device 1, or on to `S_RESEL0`.
- Soft reset: `S_RST_CTL_A` → `S_RST_WAIT_A` → `S_RST_SRST` → `S_RST_WAIT_B` → `S_RST_CTL_B` → `S_RDY_POLL`.
- Readiness: `S_RDY_POLL` loops on busy. When BSY is clear it moves to `S_SIG_SEL` or `S_FIN_SEL`. On the deadline it returns to `S_IDLE` with an error.
- Device 1 signature check: `S_SIG_SEL` → `S_SIG_RD_NS` → `S_SIG_RD_LB`. On a match it goes to `S_RDY_POLL`. On a mismatch it goes to `S_SIG_WAIT`, which leads back to `S_SIG_RD_NS` for a second try, or on to `S_RDY_POLL` after that try.
- Final selects: `S_FIN_SEL` runs up to three writes, then returns to `S_IDLE`.
- Drain: `S_DRN_STAT` ↔ `S_DRN_DATA`, then `S_IDLE`.

Top module: `ata_bringup_seq`

## Requirements
- R1: After reset, `bus_req_o`, `done_o`, `err_o` and `present_o` are all 0.
- R2: A request keeps `bus_we_o`, `bus_addr_o` and `bus_wdata_o` stable while `bus_req_o` is high until the cycle `bus_ack_i` is seen. That cycle completes the access, and `bus_rdata_i` is taken in that same cycle. Register addresses are: data 0x0, sector count 0x2, LBA low 0x3, device 0x6, status 0x7, device control 0xE.
- R3: The probe of device d runs in this order:
  - It writes 0xA0 (0xB0 when d = 1, bit 4 selecting the device) to the device register.
  - It then writes sector count 0x55, LBA low 0xAA, sector count 0xAA, LBA low 0x55, sector count 0x55, LBA low 0xAA.
  - It then reads sector count, then LBA low.
  - `present_o[d]` is set only if the low bytes read are 0x55 and 0xAA.
- R4: Device 1 is probed only when `slave_ok_i` is 1 at the start command; otherwise `present_o[1]` stays 0.
- R5: After probing, the block writes 0xA0 to the device register. It then writes `ctl_base_i`, `ctl_base_i | 0x04` (the soft-reset bit) and `ctl_base_i` to device control, with `rst_wait_i` idle cycles after each of the first two writes.
- R6: After the reset, status is read repeatedly until bit 7 (BSY) reads 0. The first such wait is always made, with device 0 selected.
- R7: If a status read still shows BSY once `deadline_i` cycles have passed since the wait began, the sequence stops with `err_o` = 1 and `done_o` = 1.
- R8: If `present_o[1]` is set, the block writes 0xB0 to the device register and reads sector count and LBA low. If both low bytes are not 0x01, it waits `retry_wait_i` cycles and reads the pair once more. In either case it then waits for device 1 to clear BSY as in R6.
- R9: The sequence ends with these device-register writes: 0xA0; then 0xB0 if device 1 is present; then 0xA0 if device 0 is present. `done_o` then rises with `err_o` = 0.
- R10: `done_o` and `err_o` hold until the next command, and accepting a command clears them. Start and drain pulses that arrive while a sequence runs have no effect on its accesses.
- R11: Drain reads status. While bit 3 (DRQ) is 1 it reads the data register and reads status again. When a status read shows DRQ = 0, it finishes with `done_o` = 1.
- R12: Drain stops after DRAIN_BYTES/2 data reads even if DRQ is still set.
- R13: Drain leaves `present_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start probe and soft-reset sequence (taken in idle) |
| drain_i | input | 1 | Start DRQ drain (taken in idle) |
| slave_ok_i | input | 1 | Allow probing of device 1 |
| ctl_base_i | input | 8 | Device-control value used around the reset pulse |
| rst_wait_i | input | CW | Cycles waited after each of the first two control writes |
| retry_wait_i | input | CW | Cycles between device 1 signature reads |
| deadline_i | input | CW | Cycle limit for a BSY wait |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 4 | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Access complete |
| bus_rdata_i | input | 16 | Read data, valid with ack |
| present_o | output | 2 | Device presence mask |
| done_o | output | 1 | Command finished |
| err_o | output | 1 | BSY wait deadline expired |

## Verification
The bench drives the sequencer against a two-device register model. It records every access and compares the list with the one the requirements predict. The probe is tried against both devices present, a missing device 1, device 1 present but not permitted, and a missing master. These cases separate a correct pattern compare from one that passes any readback. BSY lengths and signature results are varied at random so that poll counts and the single-try versus two-try signature path differ between runs. Drain is run with a DRQ burst shorter than the byte limit and with one longer than it, to tell termination on status apart from termination on the limit.

// File: rtl/abs_pkg.sv
package abs_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PRB_SEL,
        S_PRB_WR,
        S_PRB_RD_NS,
        S_PRB_RD_LB,
        S_RESEL0,
        S_RST_CTL_A,
        S_RST_WAIT_A,
        S_RST_SRST,
        S_RST_WAIT_B,
        S_RST_CTL_B,
        S_RDY_POLL,
        S_SIG_SEL,
        S_SIG_RD_NS,
        S_SIG_RD_LB,
        S_SIG_WAIT,
        S_FIN_SEL,
        S_DRN_STAT,
        S_DRN_DATA
    } seq_st_e;

    localparam logic [3:0] RA_DATA   = 4'h0;
    localparam logic [3:0] RA_NSECT  = 4'h2;
    localparam logic [3:0] RA_LBAL   = 4'h3;
    localparam logic [3:0] RA_DEVICE = 4'h6;
    localparam logic [3:0] RA_STATUS = 4'h7;
    localparam logic [3:0] RA_DEVCTL = 4'hE;

    localparam logic [7:0] DEV_SEL_BASE = 8'hA0;
    localparam logic [7:0] SRST_MASK    = 8'h04;
    localparam logic [7:0] PAT_LO       = 8'h55;
    localparam logic [7:0] PAT_HI       = 8'hAA;
    localparam logic [7:0] SIG_ONE      = 8'h01;
    localparam int         BSY_BIT      = 7;
    localparam int         DRQ_BIT      = 3;

    // Probe write k: even k targets sector count, odd k targets LBA low.
    function automatic logic [3:0] probe_addr(input logic [2:0] k);
        return k[0] ? RA_LBAL : RA_NSECT;
    endfunction

    // Pattern pairs (55,AA) (AA,55) (55,AA).
    function automatic logic [7:0] probe_byte(input logic [2:0] k);
        return (k == 3'd0 || k == 3'd3 || k == 3'd4) ? PAT_LO : PAT_HI;
    endfunction

    function automatic logic [7:0] dev_sel(input logic d);
        return DEV_SEL_BASE | {3'b000, d, 4'b0000};
    endfunction

endpackage

// File: rtl/abs_wait_timer.sv
module abs_wait_timer #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] value,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/abs_drain_tally.sv
module abs_drain_tally #(
    parameter int WORDS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int TW = $clog2(WORDS + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // True when the next data read reaches the limit.
    assign last = (cnt_q == TW'(WORDS - 1));
endmodule

// File: rtl/ata_bringup_seq.sv
module ata_bringup_seq
    import abs_pkg::*;
#(
    parameter int CW          = 24,
    parameter int DRAIN_BYTES = 65536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          drain_i,
    input  logic          slave_ok_i,
    input  logic [7:0]    ctl_base_i,
    input  logic [CW-1:0] rst_wait_i,
    input  logic [CW-1:0] retry_wait_i,
    input  logic [CW-1:0] deadline_i,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [3:0]    bus_addr_o,
    output logic [15:0]   bus_wdata_o,
    input  logic          bus_ack_i,
    input  logic [15:0]   bus_rdata_i,
    output logic [1:0]    present_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int DRAIN_WORDS = DRAIN_BYTES / 2;

    seq_st_e       st_q, st_d;
    logic          dev_q, slave_q, try_q, rdy_dev_q;
    logic [2:0]    step_q;
    logic [7:0]    ns_q;
    logic [1:0]    present_q;
    logic          done_q, err_q;

    logic          wt_load, wt_exp, dl_load, dl_exp;
    logic [CW-1:0] wt_val;
    logic          dr_clear, dr_bump, dr_last;
    logic          hit, busy_bit, sig_ok, fin_more;
    logic [7:0]    rd8;
    logic          unused_rd_hi;

    assign hit          = bus_req_o & bus_ack_i;
    assign rd8          = bus_rdata_i[7:0];
    assign busy_bit     = bus_rdata_i[BSY_BIT];
    assign sig_ok       = (ns_q == SIG_ONE) && (rd8 == SIG_ONE);
    assign fin_more     = ((step_q == 3'd0) && (present_q[1] || present_q[0])) ||
                          ((step_q == 3'd1) && present_q[0]);
    assign unused_rd_hi = ^bus_rdata_i[15:8];

    abs_wait_timer #(.CW(CW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(wt_load), .value(wt_val), .expired(wt_exp)
    );

    abs_wait_timer #(.CW(CW)) u_dline (
        .clk(clk), .rst_n(rst_n), .load(dl_load), .value(deadline_i), .expired(dl_exp)
    );

    abs_drain_tally #(.WORDS(DRAIN_WORDS)) u_tally (
        .clk(clk), .rst_n(rst_n), .clear(dr_clear), .bump(dr_bump), .last(dr_last)
    );

    // Next state and timer strobes
    always_comb begin
        st_d     = st_q;
        wt_load  = 1'b0;
        wt_val   = rst_wait_i;
        dl_load  = 1'b0;
        dr_clear = 1'b0;
        dr_bump  = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start_i) begin
                    st_d = S_PRB_SEL;
                end else if (drain_i) begin
                    st_d     = S_DRN_STAT;
                    dr_clear = 1'b1;
                end
            end
            S_PRB_SEL:   if (hit) st_d = S_PRB_WR;
            S_PRB_WR:    if (hit && step_q == 3'd5) st_d = S_PRB_RD_NS;
            S_PRB_RD_NS: if (hit) st_d = S_PRB_RD_LB;
            S_PRB_RD_LB: if (hit) st_d = (!dev_q && slave_q) ? S_PRB_SEL : S_RESEL0;
            S_RESEL0:    if (hit) st_d = S_RST_CTL_A;
            S_RST_CTL_A: begin
                if (hit) begin
                    st_d    = S_RST_WAIT_A;
                    wt_load = 1'b1;
                end
            end
            S_RST_WAIT_A: if (wt_exp) st_d = S_RST_SRST;
            S_RST_SRST: begin
                if (hit) begin
                    st_d    = S_RST_WAIT_B;
                    wt_load = 1'b1;
                end
            end
            S_RST_WAIT_B: if (wt_exp) st_d = S_RST_CTL_B;
            S_RST_CTL_B: begin
                if (hit) begin
                    st_d    = S_RDY_POLL;
                    dl_load = 1'b1;
                end
            end
            S_RDY_POLL: begin
                if (hit) begin
                    if (!busy_bit) begin
                        st_d = (rdy_dev_q || !present_q[1]) ? S_FIN_SEL : S_SIG_SEL;
                    end else if (dl_exp) begin
                        st_d = S_IDLE;
                    end
                end
            end
            S_SIG_SEL:   if (hit) st_d = S_SIG_RD_NS;
            S_SIG_RD_NS: if (hit) st_d = S_SIG_RD_LB;
            S_SIG_RD_LB: begin
                if (hit) begin
                    if (sig_ok) begin
                        st_d    = S_RDY_POLL;
                        dl_load = 1'b1;
                    end else begin
                        st_d    = S_SIG_WAIT;
                        wt_load = 1'b1;
                        wt_val  = retry_wait_i;
                    end
                end
            end
            S_SIG_WAIT: begin
                if (wt_exp) begin
                    if (try_q) begin
                        st_d    = S_RDY_POLL;
                        dl_load = 1'b1;
                    end else begin
                        st_d = S_SIG_RD_NS;
                    end
                end
            end
            S_FIN_SEL:  if (hit && !fin_more) st_d = S_IDLE;
            S_DRN_STAT: if (hit) st_d = bus_rdata_i[DRQ_BIT] ? S_DRN_DATA : S_IDLE;
            S_DRN_DATA: begin
                if (hit) begin
                    dr_bump = 1'b1;
                    st_d    = dr_last ? S_IDLE : S_DRN_STAT;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // State register and per-run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= S_IDLE;
            dev_q     <= 1'b0;
            slave_q   <= 1'b0;
            try_q     <= 1'b0;
            rdy_dev_q <= 1'b0;
            step_q    <= '0;
            ns_q      <= '0;
            present_q <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            st_q <= st_d;
            case (st_q)
                S_IDLE: begin
                    if (start_i) begin
                        dev_q     <= 1'b0;
                        slave_q   <= slave_ok_i;
                        try_q     <= 1'b0;
                        rdy_dev_q <= 1'b0;
                        step_q    <= '0;
                        present_q <= '0;
                        done_q    <= 1'b0;
                        err_q     <= 1'b0;
                    end else if (drain_i) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                    end
                end
                S_PRB_SEL: if (hit) step_q <= '0;
                S_PRB_WR:  if (hit) step_q <= step_q + 3'd1;
                S_PRB_RD_NS, S_SIG_RD_NS: if (hit) ns_q <= rd8;
                S_PRB_RD_LB: begin
                    if (hit) begin
                        present_q[dev_q] <= (ns_q == PAT_LO) && (rd8 == PAT_HI);
                        if (!dev_q && slave_q) dev_q <= 1'b1;
                    end
                end
                S_RDY_POLL: begin
                    if (hit) begin
                        if (!busy_bit) begin
                            step_q <= '0;
                        end else if (dl_exp) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end
                    end
                end
                S_SIG_SEL:  if (hit) rdy_dev_q <= 1'b1;
                S_SIG_WAIT: if (wt_exp) try_q <= 1'b1;
                S_FIN_SEL: begin
                    if (hit) begin
                        step_q <= (step_q == 3'd0 && present_q[1]) ? 3'd1 : 3'd2;
                        if (!fin_more) done_q <= 1'b1;
                    end
                end
                S_DRN_STAT: if (hit && !bus_rdata_i[DRQ_BIT]) done_q <= 1'b1;
                S_DRN_DATA: if (hit && dr_last) done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Bus request outputs decoded from state
    always_comb begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b0;
        bus_addr_o  = RA_STATUS;
        bus_wdata_o = '0;
        unique case (st_q)
            S_PRB_SEL: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = RA_DEVICE;
                bus_wdata_o = {8'h00, dev_sel(dev_q)};
            end
            S_PRB_WR: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = probe_addr(step_q);
                bus_wdata_o = {8'h00, probe_byte(step_q)};
            end
            S_PRB_RD_NS, S_SIG_RD_NS: bus_addr_o = RA_NSECT;
            S_PRB_RD_LB, S_SIG_RD_LB: bus_addr_o = RA_LBAL;
            S_RESEL0: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = RA_DEVICE;
                bus_wdata_o = {8'h00, dev_sel(1'b0)};
            end
            S_RST_CTL_A, S_RST_CTL_B: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = RA_DEVCTL;
                bus_wdata_o = {8'h00, ctl_base_i};
            end
            S_RST_SRST: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = RA_DEVCTL;
                bus_wdata_o = {8'h00, ctl_base_i | SRST_MASK};
            end
            S_RDY_POLL, S_DRN_STAT: bus_addr_o = RA_STATUS;
            S_SIG_SEL: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = RA_DEVICE;
                bus_wdata_o = {8'h00, dev_sel(1'b1)};
            end
            S_FIN_SEL: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = RA_DEVICE;
                bus_wdata_o = {8'h00, dev_sel(step_q == 3'd1)};
            end
            S_DRN_DATA: bus_addr_o = RA_DATA;
            S_IDLE, S_RST_WAIT_A, S_RST_WAIT_B, S_SIG_WAIT: bus_req_o = 1'b0;
            default: bus_req_o = 1'b0;
        endcase
    end

    assign present_o = present_q;
    assign done_o    = done_q;
    assign err_o     = err_q;
endmodule

// File: rtl/ata_bringup_seq_chk.sv
module ata_bringup_seq_chk #(
    parameter int CAP = 32768
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        we,
    input logic [3:0]  addr,
    input logic [15:0] wdata,
    input logic        ack,
    input logic        done,
    input logic        err,
    input logic [7:0]  ctl_base
);
    int unsigned data_reads;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_reads <= 0;
        end else if (done) begin
            data_reads <= 0;
        end else if (req && ack && !we && addr == 4'h0) begin
            data_reads <= data_reads + 1;
        end
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(wdata)));

    p_device_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == 4'h6) |-> (wdata == 16'h00A0 || wdata == 16'h00B0));

    p_ctl_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == 4'hE) |->
            (wdata[7:0] == ctl_base || wdata[7:0] == (ctl_base | 8'h04)));

    p_err_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req);

    p_drain_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        data_reads <= CAP);
endmodule

bind ata_bringup_seq ata_bringup_seq_chk #(.CAP(DRAIN_BYTES / 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(bus_req_o), .we(bus_we_o), .addr(bus_addr_o),
    .wdata(bus_wdata_o), .ack(bus_ack_i), .done(done_o), .err(err_o),
    .ctl_base(ctl_base_i)
);

// File: tb/ata_bringup_seq_tb.sv
module ata_bringup_seq_tb;
    localparam int CW = 16;
    localparam int DB = 16;
    localparam int NW = DB / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, drain_i = 1'b0, slave_ok_i = 1'b0;
    logic [7:0] ctl_base_i = 8'h08;
    logic [CW-1:0] rst_wait_i = 16'd20, retry_wait_i = 16'd30, deadline_i = 16'd400;
    logic bus_req_o, bus_we_o, bus_ack_i = 1'b0;
    logic [3:0] bus_addr_o;
    logic [15:0] bus_wdata_o, bus_rdata_i = '0;
    logic [1:0] present_o;
    logic done_o, err_o;

    always #4 clk = ~clk;

    ata_bringup_seq #(.CW(CW), .DRAIN_BYTES(DB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .drain_i(drain_i),
        .slave_ok_i(slave_ok_i), .ctl_base_i(ctl_base_i), .rst_wait_i(rst_wait_i),
        .retry_wait_i(retry_wait_i), .deadline_i(deadline_i),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
        .present_o(present_o), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0, errors = 0, hold_viol = 0;

    // Two-device register model
    bit m_pres[2];
    bit m_sig[2];
    int m_busy[2];
    int bcnt[2];
    logic [7:0] m_ns[2], m_lb[2];
    int sel = 0;
    int drq = 0;

    logic [20:0] log_q[256];
    logic [20:0] exp_q[256];
    int nlog = 0, nexp = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op();
        logic [7:0] r;
        if (nlog < 256) log_q[nlog] = {bus_we_o, bus_addr_o, bus_we_o ? bus_wdata_o : 16'h0};
        nlog++;
        r = 8'h00;
        if (bus_we_o) begin
            case (bus_addr_o)
                4'h6: sel = int'(bus_wdata_o[4]);
                4'h2: if (m_pres[sel]) m_ns[sel] = bus_wdata_o[7:0];
                4'h3: if (m_pres[sel]) m_lb[sel] = bus_wdata_o[7:0];
                4'hE: if (bus_wdata_o[2]) begin
                    for (int d = 0; d < 2; d++) begin
                        bcnt[d] = m_busy[d];
                        m_ns[d] = m_sig[d] ? 8'h01 : 8'h7F;
                        m_lb[d] = m_sig[d] ? 8'h01 : 8'h7F;
                    end
                end
                default: ;
            endcase
        end else begin
            case (bus_addr_o)
                4'h7: begin
                    if (!m_pres[sel]) r = 8'hFF;
                    else if (bcnt[sel] > 0) begin bcnt[sel]--; r = 8'h80; end
                    else r = (drq > 0) ? 8'h58 : 8'h50;
                end
                4'h2: r = m_pres[sel] ? m_ns[sel] : 8'hFF;
                4'h3: r = m_pres[sel] ? m_lb[sel] : 8'hFF;
                4'h0: begin if (drq > 0) drq--; r = 8'h34; end
                default: r = 8'h00;
            endcase
        end
        bus_rdata_i = {8'h12, r};
    endtask

    // Responder with random latency; also checks request stability (R2)
    initial begin
        bit pend = 0;
        int lat = 0;
        logic [20:0] held = '0;
        forever begin
            @(negedge clk);
            if (bus_ack_i) begin
                bus_ack_i = 1'b0;
            end else if (!bus_req_o) begin
                pend = 0;
            end else begin
                if (!pend) begin
                    pend = 1;
                    lat = $urandom_range(0, 2);
                    held = {bus_we_o, bus_addr_o, bus_wdata_o};
                end else if (held != {bus_we_o, bus_addr_o, bus_wdata_o}) begin
                    hold_viol++;
                end
                if (lat == 0) begin
                    do_op();
                    bus_ack_i = 1'b1;
                    pend = 0;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic ex(input bit we, input logic [3:0] a, input logic [7:0] d);
        exp_q[nexp] = {we, a, we ? {8'h00, d} : 16'h0};
        nexp++;
    endtask

    // Expected access list for a start run with the master present
    task automatic build(input bit slv, input logic [7:0] base);
        bit p1;
        nexp = 0;
        for (int dd = 0; dd < (slv ? 2 : 1); dd++) begin
            ex(1, 4'h6, dd[0] ? 8'hB0 : 8'hA0);
            ex(1, 4'h2, 8'h55); ex(1, 4'h3, 8'hAA);
            ex(1, 4'h2, 8'hAA); ex(1, 4'h3, 8'h55);
            ex(1, 4'h2, 8'h55); ex(1, 4'h3, 8'hAA);
            ex(0, 4'h2, 0); ex(0, 4'h3, 0);
        end
        ex(1, 4'h6, 8'hA0);
        ex(1, 4'hE, base); ex(1, 4'hE, base | 8'h04); ex(1, 4'hE, base);
        for (int i = 0; i <= m_busy[0]; i++) ex(0, 4'h7, 0);
        p1 = slv && m_pres[1];
        if (p1) begin
            ex(1, 4'h6, 8'hB0);
            ex(0, 4'h2, 0); ex(0, 4'h3, 0);
            if (!m_sig[1]) begin ex(0, 4'h2, 0); ex(0, 4'h3, 0); end
            for (int i = 0; i <= m_busy[1]; i++) ex(0, 4'h7, 0);
        end
        ex(1, 4'h6, 8'hA0);
        if (p1) ex(1, 4'h6, 8'hB0);
        if (m_pres[0]) ex(1, 4'h6, 8'hA0);
    endtask

    task automatic cmp_log(input string tag);
        int bad = -1;
        chk(nlog == nexp, {tag, " access count"}, nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++)
            if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
        if (bad >= 0) chk(0, {tag, " access list"}, int'(log_q[bad]), int'(exp_q[bad]));
        else chk(1, tag, 0, 0);
    endtask

    task automatic run_cmd(input bit drain, input bit slv, input logic [7:0] base,
                           input bit poke);
        slave_ok_i = slv;
        ctl_base_i = base;
        nlog = 0;
        @(negedge clk);
        if (drain) drain_i = 1'b1; else start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drain_i = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            start_i = 1'b1;
            drain_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            drain_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_model(input bit p0, input bit p1, input int b0, input int b1,
                             input bit s1);
        m_pres[0] = p0; m_pres[1] = p1;
        m_busy[0] = b0; m_busy[1] = b1;
        m_sig[0] = 1'b1; m_sig[1] = s1;
        bcnt[0] = 0; bcnt[1] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit slv, p1, s1;
        int b0, b1;
        logic [7:0] base;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_req_o == 1'b0, "R1 req", bus_req_o, 0);
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(err_o == 1'b0, "R1 err", err_o, 0);
        chk(present_o == 2'b00, "R1 present", present_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Both present, long busy, start/drain poked mid-run (R3 R5 R6 R9 R10)
        set_model(1, 1, 2, 3, 1);
        build(1, 8'h08);
        run_cmd(0, 1, 8'h08, 1);
        cmp_log("R3 R5 R6 R9 R10 both present");
        chk(present_o == 2'b11, "R3 present mask", present_o, 3);
        chk(err_o == 1'b0, "R9 no error", err_o, 0);

        // Device 1 present but not permitted (R4)
        set_model(1, 1, 0, 0, 1);
        build(0, 8'h00);
        run_cmd(0, 0, 8'h00, 0);
        cmp_log("R4 slave not permitted");
        chk(present_o == 2'b01, "R4 present mask", present_o, 1);

        // Device 1 permitted but absent (R3)
        set_model(1, 0, 1, 0, 1);
        build(1, 8'h02);
        run_cmd(0, 1, 8'h02, 0);
        cmp_log("R3 slave absent");
        chk(present_o == 2'b01, "R3 absent mask", present_o, 1);

        // Signature mismatch: two tries (R8)
        set_model(1, 1, 0, 1, 0);
        build(1, 8'h08);
        run_cmd(0, 1, 8'h08, 0);
        cmp_log("R8 signature retry");

        // Master absent: BSY wait times out (R7)
        set_model(0, 0, 0, 0, 1);
        deadline_i = 16'd40;
        run_cmd(0, 0, 8'h08, 0);
        chk(err_o == 1'b1, "R7 timeout err", err_o, 1);
        chk(done_o == 1'b1, "R7 timeout done", done_o, 1);
        chk(present_o == 2'b00, "R7 present mask", present_o, 0);
        deadline_i = 16'd400;

        // Random runs (R3 R6 R8 R9)
        for (int n = 0; n < 10; n++) begin
            p1 = 1'($urandom % 2); slv = 1'($urandom % 2); s1 = 1'($urandom % 2);
            b0 = int'($urandom % 5); b1 = int'($urandom % 5);
            base = 8'($urandom) & 8'hFB;
            set_model(1, p1, b0, b1, s1);
            build(slv, base);
            run_cmd(0, slv, base, 0);
            cmp_log("R6 R8 R9 random run");
            chk(present_o == {slv & p1, 1'b1}, "R3 random mask", present_o, {slv & p1, 1'b1});
            chk(err_o == 1'b0, "R7 random no error", err_o, 0);
        end

        // Drain shorter than the limit (R11 R13)
        set_model(1, 1, 0, 0, 1);
        build(1, 8'h08);
        run_cmd(0, 1, 8'h08, 0);
        drq = 5;
        nexp = 0;
        for (int i = 0; i < 5; i++) begin ex(0, 4'h7, 0); ex(0, 4'h0, 0); end
        ex(0, 4'h7, 0);
        run_cmd(1, 0, 8'h08, 0);
        cmp_log("R11 drain to DRQ clear");
        chk(present_o == 2'b11, "R13 present kept", present_o, 3);
        chk(err_o == 1'b0, "R11 no error", err_o, 0);

        // Drain longer than the limit (R12)
        drq = 20;
        nexp = 0;
        for (int i = 0; i < NW; i++) begin ex(0, 4'h7, 0); ex(0, 4'h0, 0); end
        run_cmd(1, 0, 8'h08, 0);
        cmp_log("R12 drain limit");
        chk(drq == 20 - NW, "R12 words left", drq, 20 - NW);

        chk(hold_viol == 0, "R2 request held until ack", hold_viol, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule